// File: doc/BRIEF.md
# Windowed Watchdog Timer with Standby Control

The block is a watchdog counter clocked from a slow, always-running clock. It counts from zero toward one of eight overflow periods, each a power of two, picked by a 3-bit code. If the count reaches the selected period, the block pulses a reset request for the rest of the chip. Software keeps the system alive by writing a fixed key byte to a service register. That write is only accepted while a service window is open, and the window covers the late part of each period.

A write with the wrong byte raises the reset request at once. So does a correct key written too early. An optional interval interrupt pulses at three quarters of the period, so firmware can service the timer from an interrupt handler.

A standby flag says whether counting freezes or continues while the system sleeps in either low-power mode. When counting freezes, waking up clears the count, so the full period is available again. The period code, the window size, the interrupt enable and the standby flag are all captured while reset is held. They stay fixed until the next reset. Only the standby input stops the count: the block keeps running through any other activity, such as flash self-programming.

Top module: `wwdt`

## Requirements
- R1: The period code maps 0 to 7 onto 2^(e-SCALE) clocks with e = 10, 11, 12, 13, 15, 17, 18, 20 (SCALE defaults to 0). Counting starts at zero when reset is released, and `rst_req` goes high on the P-th rising edge after release.
- R2: `rst_req` is high for exactly one cycle. The count is cleared with it and held at zero for one more cycle, so a free-running overflow repeats every P+1 cycles.
- R3: Writing 0xAC while the window is open clears the count, so the next overflow comes P cycles after the clock edge that takes the write.
- R4: Window code 00 opens the window at count P/2. Code 01 opens it at P/4. Codes 10 and 11 keep it open at every count. The window stays open up to the overflow.
- R5: Writing 0xAC while the window is closed raises `rst_req` in the next cycle and clears the count.
- R6: Writing any byte other than 0xAC raises `rst_req` in the next cycle, whether the window is open or not.
- R7: With the interrupt enabled, `irq` pulses for one cycle when the count reaches 3P/4. With the interrupt disabled, `irq` never rises.
- R8: With the standby flag at 0, the count holds its value while `standby` is high.
- R9: With the standby flag at 0, the first cycle after `standby` falls clears the count to zero, and counting resumes from there.
- R10: With the standby flag at 1, `standby` has no effect on counting, overflow or the interrupt.
- R11: The four configuration inputs are sampled only while `rst` is high. Changing them later has no effect.
- R12: While `rst` is high, `rst_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow watchdog clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| cfg_period_sel | input | 3 | Overflow period code |
| cfg_window_sel | input | 2 | Service window size code |
| cfg_irq_en | input | 1 | Enables the interval interrupt |
| cfg_standby_run | input | 1 | 1: keep counting in standby; 0: freeze, then clear on wake |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 8 | Byte written to the service register |
| standby | input | 1 | High while the system is in either low-power mode |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | One-cycle interval interrupt |

## Verification
The bench takes cycle C as the falling edge at which reset is released, or at which a write or standby exit is driven. It then predicts each event cycle as an offset from the cycle in which the count was last zero. After reset release, `irq` is due at C+3P/4 and `rst_req` at C+P. A service write at C restarts the count on edge C+1, so the next overflow falls at C+1+P. A rejected write shows `rst_req` at C+1. A wake from a frozen standby ending at C clears the count on edge C+1. The driver pushes each predicted pulse with its cycle into a queue. A monitor sampling on falling edges pops one entry per observed pulse and compares the kind and the cycle. At the end of each scenario the bench confirms that no predicted pulse is still pending.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    localparam logic [7:0] SERVICE_KEY = 8'hAC;

    typedef struct packed {
        logic [2:0] period_sel;
        logic [1:0] window_sel;
        logic       irq_en;
        logic       standby_run;
    } wdt_cfg_t;

    typedef enum logic [1:0] {
        WIN_HALF    = 2'b00,
        WIN_3QUART  = 2'b01,
        WIN_FULL    = 2'b10,
        WIN_FULL_B  = 2'b11
    } win_mode_e;

    // Exponent of the overflow period for each code (non-uniform steps)
    function automatic int unsigned period_exp(input logic [2:0] sel);
        case (sel)
            3'd0:    return 10;
            3'd1:    return 11;
            3'd2:    return 12;
            3'd3:    return 13;
            3'd4:    return 15;
            3'd5:    return 17;
            3'd6:    return 18;
            default: return 20;
        endcase
    endfunction

    function automatic int unsigned period_len(input logic [2:0] sel, input int unsigned scale);
        return 32'd1 << (period_exp(sel) - scale);
    endfunction

    // First count at which a service write is accepted
    function automatic int unsigned window_start(input logic [1:0] wsel, input int unsigned plen);
        case (win_mode_e'(wsel))
            WIN_HALF:   return plen >> 1;
            WIN_3QUART: return plen >> 2;
            default:    return 0;
        endcase
    endfunction

    function automatic int unsigned irq_point(input int unsigned plen);
        return plen - (plen >> 2);
    endfunction

endpackage

// File: rtl/wwdt_cfg_latch.sv
module wwdt_cfg_latch
    import wwdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wdt_cfg_t cfg_in,
    output wdt_cfg_t cfg_q
);

    // Follows the inputs only while reset is held; frozen afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    input  logic             standby_run,
    input  logic             standby,
    input  logic             restart,
    input  logic             fault,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             wrap
);

    logic stby_q;
    logic wake_clr;
    logic frozen;

    always_ff @(posedge clk) begin
        if (rst) begin
            stby_q <= 1'b0;
        end else begin
            stby_q <= standby;
        end
    end

    assign frozen   = standby && !standby_run;
    assign wake_clr = !standby_run && stby_q && !standby;
    assign running  = !frozen && !wake_clr && !hold;
    assign wrap     = running && (cnt == period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart || fault || hold || wake_clr || wrap) begin
            cnt <= '0;
        end else if (running) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wwdt_key_check.sv
module wwdt_key_check
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 21
) (
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] win_start,
    output logic             restart,
    output logic             fault
);

    logic key_ok;
    logic win_open;

    assign key_ok   = (wr_data == SERVICE_KEY);
    assign win_open = (cnt >= win_start);
    assign restart  = wr_en && key_ok && win_open;
    assign fault    = wr_en && !(key_ok && win_open);

endmodule

// File: rtl/wwdt.sv
module wwdt
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 21,
    parameter int SCALE = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cfg_period_sel,
    input  logic [1:0] cfg_window_sel,
    input  logic       cfg_irq_en,
    input  logic       cfg_standby_run,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       standby,
    output logic       rst_req,
    output logic       irq
);

    wdt_cfg_t         cfg_in;
    wdt_cfg_t         cfg_q;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] win_start;
    logic [CNT_W-1:0] irq_mark;
    logic [CNT_W-1:0] cnt;
    logic             restart;
    logic             fault;
    logic             running;
    logic             wrap;

    assign cfg_in = '{period_sel:  cfg_period_sel,
                      window_sel:  cfg_window_sel,
                      irq_en:      cfg_irq_en,
                      standby_run: cfg_standby_run};

    wwdt_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    always_comb begin
        period    = CNT_W'(period_len(cfg_q.period_sel, SCALE));
        win_start = CNT_W'(window_start(cfg_q.window_sel, period_len(cfg_q.period_sel, SCALE)));
        irq_mark  = CNT_W'(irq_point(period_len(cfg_q.period_sel, SCALE)));
    end

    wwdt_key_check #(.CNT_W(CNT_W)) u_key (
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cnt       (cnt),
        .win_start (win_start),
        .restart   (restart),
        .fault     (fault)
    );

    wwdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .period      (period),
        .standby_run (cfg_q.standby_run),
        .standby     (standby),
        .restart     (restart),
        .fault       (fault),
        .hold        (rst_req),
        .cnt         (cnt),
        .running     (running),
        .wrap        (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= fault || (wrap && !restart);
            irq     <= cfg_q.irq_en && running && !restart && !fault
                       && (cnt == irq_mark - 1'b1);
        end
    end

endmodule

// File: rtl/wwdt_sva.sv
module wwdt_checker
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 21,
    parameter int SCALE = 0
) (
    input logic             clk,
    input logic             rst,
    input wdt_cfg_t         cfg,
    input logic [CNT_W-1:0] cnt,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             standby,
    input logic             rst_req,
    input logic             irq
);

    logic [CNT_W-1:0] open_at;
    assign open_at = CNT_W'(window_start(cfg.window_sel, period_len(cfg.period_sel, SCALE)));

    a_r2_hold_zero: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> (cnt == '0));

    a_r5_closed_window: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data == SERVICE_KEY && cnt < open_at) |=> rst_req);

    a_r6_bad_key: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data != SERVICE_KEY) |=> rst_req);

    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
        (standby && !cfg.standby_run && !wr_en) |=> $stable(cnt));

    a_r9_wake_clear: assert property (@(posedge clk) disable iff (rst)
        (!cfg.standby_run && !$past(rst) && $past(standby) && !standby) |=> (cnt == '0));

    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg));

endmodule

bind wwdt wwdt_checker #(.CNT_W(CNT_W), .SCALE(SCALE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg_q),
    .cnt     (cnt),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .standby (standby),
    .rst_req (rst_req),
    .irq     (irq)
);

// File: tb/wwdt_test.sv
module wwdt_test;

    localparam int CNT_W = 21;
    localparam int SCALE = 6;
    localparam int K_RST = 0;
    localparam int K_IRQ = 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] psel = 3'd0;
    logic [1:0] wsel = 2'd0;
    logic       ien = 1'b0;
    logic       srun = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       standby = 1'b0;
    logic       rst_req;
    logic       irq;

    always #2 clk = ~clk;

    wwdt #(.CNT_W(CNT_W), .SCALE(SCALE)) uut (
        .clk             (clk),
        .rst             (rst),
        .cfg_period_sel  (psel),
        .cfg_window_sel  (wsel),
        .cfg_irq_en      (ien),
        .cfg_standby_run (srun),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .standby         (standby),
        .rst_req         (rst_req),
        .irq             (irq)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    int base = 0;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;

    ev_t sb[$];

    function automatic int plen(input int sel);
        int e;
        case (sel)
            0: e = 10;  1: e = 11;  2: e = 12;  3: e = 13;
            4: e = 15;  5: e = 17;  6: e = 18;  default: e = 20;
        endcase
        return 1 << (e - SCALE);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int at, input string req);
        ev_t e;
        e.kind = kind;
        e.at   = at;
        e.req  = req;
        sb.push_back(e);
    endtask

    task automatic see(input int kind);
        ev_t e;
        if (sb.size() == 0) begin
            check(1'b0, (kind == K_IRQ) ? "R7" : "R1", "unexpected pulse kind", kind, -1);
        end else begin
            e = sb.pop_front();
            check(e.kind == kind, e.req, "pulse kind", kind, e.kind);
            check(e.at == cyc, e.req, "pulse cycle", cyc, e.at);
        end
    endtask

    // Monitor: compare every observed pulse against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rst_req) see(K_RST);
            if (irq)     see(K_IRQ);
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] p, input logic [1:0] w,
                            input logic ie, input logic sr);
        @(negedge clk);
        rst = 1'b1; psel = p; wsel = w; ien = ie; srun = sr;
        standby = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(rst_req == 1'b0 && irq == 1'b0, "R12", "outputs in reset",
                  {30'd0, rst_req, irq}, 0);
        end
        rst  = 1'b0;
        base = cyc;
    endtask

    task automatic write_at(input int c, input logic [7:0] d);
        wait_until(c);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic end_at(input int c, input string req);
        wait_until(c);
        check(sb.size() == 0, req, "pending predicted pulses", sb.size(), 0);
        sb.delete();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int p;
        int c;

        // R1 R2 R7: every period code, two free-running periods each
        for (int s = 0; s < 8; s++) begin
            do_reset(3'(s), 2'b00, 1'b1, 1'b0);
            p = plen(s);
            push(K_IRQ, base + (p - p / 4), "R7");
            push(K_RST, base + p, "R1");
            push(K_IRQ, base + p + 1 + (p - p / 4), "R7");
            push(K_RST, base + 2 * p + 1, "R2");
            end_at(base + 2 * p + 4, "R1");
        end

        // R3 R4 R5 R6 R7: P=128, half window (opens at 64), interrupt off
        do_reset(3'd3, 2'b00, 1'b0, 1'b0);
        c = base + 64;
        write_at(c, 8'hAC);                 // R3: boundary count 64 accepted
        base = c + 1;
        c = base + 63;
        write_at(c, 8'hAC);                 // R5: count 63, window closed
        push(K_RST, c + 1, "R5");
        base = c + 2;
        c = base + 100;
        write_at(c, 8'h53);                 // R6: wrong byte inside window
        push(K_RST, c + 1, "R6");
        base = c + 2;
        push(K_RST, base + 128, "R3");
        end_at(base + 135, "R7");

        // R4: P=512, three-quarter window opens at 128
        do_reset(3'd4, 2'b01, 1'b1, 1'b0);
        c = base + 128;
        write_at(c, 8'hAC);                 // accepted at boundary
        base = c + 1;
        c = base + 127;
        write_at(c, 8'hAC);                 // rejected one count early
        push(K_RST, c + 1, "R4");
        end_at(c + 5, "R4");

        // R4: full window, service accepted at small counts
        do_reset(3'd0, 2'b10, 1'b1, 1'b0);
        c = base + 3;
        write_at(c, 8'hAC);
        base = c + 1;
        c = base + 1;
        write_at(c, 8'hAC);
        base = c + 1;
        push(K_IRQ, base + 12, "R7");
        push(K_RST, base + 16, "R4");
        end_at(base + 20, "R4");

        // R8 R9: freeze in standby, clear on wake (P=16)
        do_reset(3'd0, 2'b00, 1'b1, 1'b0);
        wait_until(base + 5);
        standby = 1'b1;
        wait_until(base + 25);
        standby = 1'b0;
        base = base + 26;
        push(K_IRQ, base + 12, "R9");
        push(K_RST, base + 16, "R8");
        end_at(base + 20, "R8");

        // R10: standby ignored when the run flag is set
        do_reset(3'd0, 2'b00, 1'b1, 1'b1);
        push(K_IRQ, base + 12, "R10");
        push(K_RST, base + 16, "R10");
        wait_until(base + 5);
        standby = 1'b1;
        wait_until(base + 25);
        standby = 1'b0;
        end_at(base + 28, "R10");

        // R11: inputs changed after release have no effect
        do_reset(3'd1, 2'b11, 1'b0, 1'b0);
        psel = 3'd0; wsel = 2'b00; ien = 1'b1;
        c = base + 2;
        write_at(c, 8'hAC);                 // accepted only with latched full window
        base = c + 1;
        push(K_RST, base + 32, "R11");
        end_at(base + 36, "R11");

        finish_run();
    end

endmodule